// File: doc/BRIEF.md
# Receive Descriptor Completion Controller

This controller runs once each time a receive context reaches the end of a descriptor program. It is pulsed with a completion strobe, an outcome flag and the values to report. It first writes the completion status back: the event code goes to the context control register, and the transfer status and residual byte count go to the final descriptor. It then takes one of two paths. On the failure path it may raise an unrecoverable-error interrupt, and it parks the command pointer on the failing descriptor. On the success path it may raise the request-receive or response-receive interrupt, and it either stops or follows the descriptor's branch address and asks for the next program to be loaded.

Each register update appears as a one-cycle write strobe with its value. Interrupt bits are sticky and are cleared one at a time through a clear vector. The command pointer is kept aligned to 2^ALIGN_BITS bytes. A new completion is taken only while the controller is idle.

Top module: `rx_done_ctrl`

## Requirements
- R1: After reset, every write strobe, `load_req`, all three interrupt bits, `busy` and `cmd_ptr` are zero.
- R2: A `done_vld` pulse taken while idle produces, in the next cycle, a single-cycle `ctl_evt_we` with `ctl_evt_val` equal to the event code, together with a single-cycle `dsc_stat_we` carrying the transfer status in `dsc_stat_val` and the residual count in `dsc_res_val`.
- R3: A `done_vld` pulse that arrives while `busy` is 1 has no effect: it produces no further status write, and it changes neither the pointer nor the interrupts.
- R4: When `done_ok` is 0, a one-cycle `cmd_ptr_we` appears two cycles after the status write. `cmd_ptr` then equals `desc_addr` with its low ALIGN_BITS bits cleared, and `load_req` stays 0.
- R5: On the failure path, `irq_unrec` is set only when `int_fld` is 2'b11.
- R6: On the success path with `int_fld` equal to 2'b11, `irq_rqst` is set when `ctx_resp` is 0 and `irq_resp` is set when `ctx_resp` is 1. No bit is set for any other `int_fld` value.
- R7: On the success path with `z_fld` equal to zero, no `cmd_ptr_we` or `load_req` occurs and `cmd_ptr` keeps its value.
- R8: On the success path with a nonzero `z_fld`, `cmd_ptr_we` and `load_req` pulse together for one cycle, two cycles after the status write. `cmd_ptr` then equals `branch_addr` with its low ALIGN_BITS bits cleared.
- R9: Interrupt bits stay set until the matching bit of `irq_clr` is pulsed (bit 0 unrecoverable, bit 1 request, bit 2 response). A set and a clear of the same bit in the same cycle leave the bit set.
- R10: `busy` is 1 during the status-write cycle and the decision cycle. It is 0 in the cycle that carries the result strobes, and a completion can be accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_vld | input | 1 | Completion strobe |
| done_ok | input | 1 | 1 when the program was processed correctly |
| evt_code | input | EVT_W | Event code to report |
| xfer_stat | input | STAT_W | Transfer status for the final descriptor |
| res_cnt | input | CNT_W | Remaining host byte count |
| int_fld | input | 2 | Interrupt field of the final descriptor |
| z_fld | input | Z_W | Z field of the final descriptor |
| branch_addr | input | ADDR_W | Branch address of the final descriptor |
| desc_addr | input | ADDR_W | Host address of the current descriptor |
| ctx_resp | input | 1 | 0 request context, 1 response context |
| irq_clr | input | 3 | Per-bit interrupt clear pulses |
| ctl_evt_we | output | 1 | Context control event-code write strobe |
| ctl_evt_val | output | EVT_W | Event code being written |
| dsc_stat_we | output | 1 | Descriptor status write strobe |
| dsc_stat_val | output | STAT_W | Transfer status being written |
| dsc_res_val | output | CNT_W | Residual count being written |
| cmd_ptr_we | output | 1 | Command pointer write strobe |
| cmd_ptr | output | ADDR_W | Command pointer descriptor address |
| load_req | output | 1 | Request to load the next program |
| irq_unrec | output | 1 | Sticky unrecoverable-error interrupt |
| irq_rqst | output | 1 | Sticky request-receive interrupt |
| irq_resp | output | 1 | Sticky response-receive interrupt |
| busy | output | 1 | Completion in progress |

## Verification
The bench builds the block with its default parameters: a 5-bit event code, 16-bit status and residual count, a 4-bit Z field and 32-bit addresses with 16-byte alignment. The Z value 8 sets only the top bit of the field, so a check that looks at the low bit alone would wrongly report zero. Addresses with nonzero low nibbles show whether the alignment mask is applied, and all-ones status and residual values cover the full width of the write-back buses.

// File: rtl/rx_done_pkg.sv
package rx_done_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_ERR  = 2'd2,
    ST_OK   = 2'd3
  } seq_st_e;

  localparam int IRQ_N     = 3;
  localparam int IRQ_UNREC = 0;
  localparam int IRQ_RQST  = 1;
  localparam int IRQ_RESP  = 2;
  localparam logic [1:0] INT_ALWAYS = 2'b11;
endpackage

// File: rtl/rx_done_seq.sv
module rx_done_seq
  import rx_done_pkg::*;
#(
  parameter int EVT_W  = 5,
  parameter int STAT_W = 16,
  parameter int CNT_W  = 16,
  parameter int Z_W    = 4,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_vld,
  input  logic              done_ok,
  input  logic [EVT_W-1:0]  evt_code,
  input  logic [STAT_W-1:0] xfer_stat,
  input  logic [CNT_W-1:0]  res_cnt,
  input  logic [1:0]        int_fld,
  input  logic [Z_W-1:0]    z_fld,
  input  logic [ADDR_W-1:0] branch_addr,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic              ctx_resp,
  output logic              wb_fire,
  output logic [EVT_W-1:0]  evt_q,
  output logic [STAT_W-1:0] stat_q,
  output logic [CNT_W-1:0]  res_q,
  output logic [IRQ_N-1:0]  irq_set,
  output logic              ptr_upd,
  output logic [ADDR_W-1:0] ptr_val,
  output logic              load_fire,
  output logic              busy
);
  seq_st_e st_q, st_d;
  logic              cap_en;
  logic              ok_q, resp_q;
  logic [1:0]        int_q;
  logic              z_nz_q;
  logic [ADDR_W-1:0] br_q, da_q;
  logic              int_hit;

  assign cap_en = (st_q == ST_IDLE) && done_vld;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (done_vld) st_d = ST_WB;
      ST_WB:   st_d = ok_q ? ST_OK : ST_ERR;
      ST_ERR:  st_d = ST_IDLE;
      ST_OK:   st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q   <= 1'b0;
      resp_q <= 1'b0;
      int_q  <= 2'b00;
      z_nz_q <= 1'b0;
      evt_q  <= '0;
      stat_q <= '0;
      res_q  <= '0;
      br_q   <= '0;
      da_q   <= '0;
    end else if (cap_en) begin
      ok_q   <= done_ok;
      resp_q <= ctx_resp;
      int_q  <= int_fld;
      z_nz_q <= |z_fld;
      evt_q  <= evt_code;
      stat_q <= xfer_stat;
      res_q  <= res_cnt;
      br_q   <= branch_addr;
      da_q   <= desc_addr;
    end
  end

  assign int_hit = (int_q == INT_ALWAYS);
  assign wb_fire = (st_q == ST_WB);
  assign busy    = (st_q != ST_IDLE);

  always_comb begin
    irq_set   = '0;
    ptr_upd   = 1'b0;
    ptr_val   = da_q;
    load_fire = 1'b0;
    if (st_q == ST_ERR) begin
      irq_set[IRQ_UNREC] = int_hit;
      ptr_upd            = 1'b1;
      ptr_val            = da_q;
    end else if (st_q == ST_OK) begin
      irq_set[IRQ_RQST] = int_hit && !resp_q;
      irq_set[IRQ_RESP] = int_hit && resp_q;
      ptr_upd           = z_nz_q;
      ptr_val           = br_q;
      load_fire         = z_nz_q;
    end
  end
endmodule

// File: rtl/rx_done_irq.sv
module rx_done_irq #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] bits_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic q, d, en;
    assign en = set_i[g] | clr_i[g];
    assign d  = set_i[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (en) q <= d;
    end
    assign bits_o[g] = q;
  end
endmodule

// File: rtl/rx_done_cmdptr.sv
module rx_done_cmdptr #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_i,
  input  logic [ADDR_W-1:0] val_i,
  input  logic              load_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              load_o
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = {{(ADDR_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_o <= '0;
    else if (upd_i) ptr_o <= val_i & ALIGN_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_o   <= 1'b0;
      load_o <= 1'b0;
    end else begin
      we_o   <= upd_i;
      load_o <= load_i;
    end
  end
endmodule

// File: rtl/rx_done_ctrl.sv
module rx_done_ctrl
  import rx_done_pkg::*;
#(
  parameter int EVT_W      = 5,
  parameter int STAT_W     = 16,
  parameter int CNT_W      = 16,
  parameter int Z_W        = 4,
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_vld,
  input  logic              done_ok,
  input  logic [EVT_W-1:0]  evt_code,
  input  logic [STAT_W-1:0] xfer_stat,
  input  logic [CNT_W-1:0]  res_cnt,
  input  logic [1:0]        int_fld,
  input  logic [Z_W-1:0]    z_fld,
  input  logic [ADDR_W-1:0] branch_addr,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic              ctx_resp,
  input  logic [2:0]        irq_clr,
  output logic              ctl_evt_we,
  output logic [EVT_W-1:0]  ctl_evt_val,
  output logic              dsc_stat_we,
  output logic [STAT_W-1:0] dsc_stat_val,
  output logic [CNT_W-1:0]  dsc_res_val,
  output logic              cmd_ptr_we,
  output logic [ADDR_W-1:0] cmd_ptr,
  output logic              load_req,
  output logic              irq_unrec,
  output logic              irq_rqst,
  output logic              irq_resp,
  output logic              busy
);
  logic              wb_fire;
  logic [IRQ_N-1:0]  irq_set, irq_bits;
  logic              ptr_upd, load_fire;
  logic [ADDR_W-1:0] ptr_val;

  rx_done_seq #(
    .EVT_W(EVT_W), .STAT_W(STAT_W), .CNT_W(CNT_W), .Z_W(Z_W), .ADDR_W(ADDR_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .done_vld(done_vld), .done_ok(done_ok),
    .evt_code(evt_code), .xfer_stat(xfer_stat), .res_cnt(res_cnt),
    .int_fld(int_fld), .z_fld(z_fld), .branch_addr(branch_addr),
    .desc_addr(desc_addr), .ctx_resp(ctx_resp),
    .wb_fire(wb_fire), .evt_q(ctl_evt_val), .stat_q(dsc_stat_val),
    .res_q(dsc_res_val), .irq_set(irq_set), .ptr_upd(ptr_upd),
    .ptr_val(ptr_val), .load_fire(load_fire), .busy(busy)
  );

  rx_done_irq #(.N(IRQ_N)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_i(irq_set), .clr_i(irq_clr), .bits_o(irq_bits)
  );

  rx_done_cmdptr #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_ptr (
    .clk(clk), .rst_n(rst_n), .upd_i(ptr_upd), .val_i(ptr_val),
    .load_i(load_fire), .we_o(cmd_ptr_we), .ptr_o(cmd_ptr), .load_o(load_req)
  );

  assign ctl_evt_we  = wb_fire;
  assign dsc_stat_we = wb_fire;
  assign irq_unrec   = irq_bits[IRQ_UNREC];
  assign irq_rqst    = irq_bits[IRQ_RQST];
  assign irq_resp    = irq_bits[IRQ_RESP];
endmodule

// File: rtl/rx_done_chk.sv
module rx_done_chk #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done_vld,
  input logic              busy,
  input logic              ctl_evt_we,
  input logic              dsc_stat_we,
  input logic              cmd_ptr_we,
  input logic [ADDR_W-1:0] cmd_ptr,
  input logic              load_req,
  input logic              irq_unrec,
  input logic              irq_rqst,
  input logic              irq_resp,
  input logic [2:0]        irq_clr
);
  // R2
  wb_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_evt_we |-> dsc_stat_we);
  // R2
  wb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_evt_we |=> !ctl_evt_we);
  // R10
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_vld && !busy) |=> ctl_evt_we);
  // R3
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_vld && busy && !ctl_evt_we) |=> !ctl_evt_we);
  // R4
  ptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ptr_we |-> (cmd_ptr[ALIGN_BITS-1:0] == '0));
  // R8
  load_with_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |-> cmd_ptr_we);
  // R5
  unrec_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_unrec) |-> (cmd_ptr_we && !load_req));
  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rqst && !irq_clr[1]) |=> irq_rqst);
  // R6
  one_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(irq_rqst) && $rose(irq_resp)));
endmodule

bind rx_done_ctrl rx_done_chk #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .done_vld(done_vld), .busy(busy),
  .ctl_evt_we(ctl_evt_we), .dsc_stat_we(dsc_stat_we), .cmd_ptr_we(cmd_ptr_we),
  .cmd_ptr(cmd_ptr), .load_req(load_req), .irq_unrec(irq_unrec),
  .irq_rqst(irq_rqst), .irq_resp(irq_resp), .irq_clr(irq_clr)
);

// File: tb/sim_rx_done_ctrl.sv
`timescale 1ns/1ps
module sim_rx_done_ctrl;
  logic        clk, rst_n;
  logic        done_vld, done_ok, ctx_resp;
  logic [4:0]  evt_code;
  logic [15:0] xfer_stat, res_cnt;
  logic [1:0]  int_fld;
  logic [3:0]  z_fld;
  logic [31:0] branch_addr, desc_addr;
  logic [2:0]  irq_clr;
  logic        ctl_evt_we, dsc_stat_we, cmd_ptr_we, load_req, busy;
  logic        irq_unrec, irq_rqst, irq_resp;
  logic [4:0]  ctl_evt_val;
  logic [15:0] dsc_stat_val, dsc_res_val;
  logic [31:0] cmd_ptr;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_ptr;
  logic [2:0]  exp_irq;

  rx_done_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .done_vld(done_vld), .done_ok(done_ok),
    .evt_code(evt_code), .xfer_stat(xfer_stat), .res_cnt(res_cnt),
    .int_fld(int_fld), .z_fld(z_fld), .branch_addr(branch_addr),
    .desc_addr(desc_addr), .ctx_resp(ctx_resp), .irq_clr(irq_clr),
    .ctl_evt_we(ctl_evt_we), .ctl_evt_val(ctl_evt_val),
    .dsc_stat_we(dsc_stat_we), .dsc_stat_val(dsc_stat_val),
    .dsc_res_val(dsc_res_val), .cmd_ptr_we(cmd_ptr_we), .cmd_ptr(cmd_ptr),
    .load_req(load_req), .irq_unrec(irq_unrec), .irq_rqst(irq_rqst),
    .irq_resp(irq_resp), .busy(busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] irqv();
    return {irq_resp, irq_rqst, irq_unrec};
  endfunction

  // Drives one completion and checks the status write and the result cycle.
  task automatic run_done(input logic ok, input logic [4:0] ev, input logic [15:0] st,
                          input logic [15:0] rc, input logic [1:0] itf, input logic [3:0] z,
                          input logic [31:0] br, input logic [31:0] da, input logic rs,
                          input logic poke_busy, input logic [2:0] clr_dec);
    logic exp_we, exp_ld;
    @(negedge clk);
    done_vld = 1; done_ok = ok; evt_code = ev; xfer_stat = st; res_cnt = rc;
    int_fld = itf; z_fld = z; branch_addr = br; desc_addr = da; ctx_resp = rs;
    @(negedge clk);
    done_vld = poke_busy;
    if (poke_busy) begin evt_code = ~ev; desc_addr = ~da; done_ok = ~ok; end
    chk("R2 evt we", {63'd0, ctl_evt_we}, 64'd1);
    chk("R2 evt val", {59'd0, ctl_evt_val}, {59'd0, ev});
    chk("R2 stat we", {63'd0, dsc_stat_we}, 64'd1);
    chk("R2 stat/res", {32'd0, dsc_stat_val, dsc_res_val}, {32'd0, st, rc});
    chk("R10 busy wb", {63'd0, busy}, 64'd1);
    @(negedge clk);
    done_vld = 0;
    irq_clr = clr_dec;
    chk("R10 busy dec", {63'd0, busy}, 64'd1);
    chk("R3 no re-write", {63'd0, ctl_evt_we}, 64'd0);
    exp_we = 0; exp_ld = 0;
    exp_irq = exp_irq & ~clr_dec;
    if (!ok) begin
      exp_we = 1; exp_ptr = da & 32'hFFFF_FFF0;
      if (itf == 2'b11) exp_irq[0] = 1;
    end else begin
      if (itf == 2'b11) exp_irq[rs ? 2 : 1] = 1;
      if (z != 0) begin exp_we = 1; exp_ld = 1; exp_ptr = br & 32'hFFFF_FFF0; end
    end
    @(negedge clk);
    irq_clr = 0;
    chk(ok ? "R8/R7 ptr we" : "R4 ptr we", {63'd0, cmd_ptr_we}, {63'd0, exp_we});
    chk(ok ? "R8 load" : "R4 load", {63'd0, load_req}, {63'd0, exp_ld});
    chk(ok ? "R8/R7 ptr" : "R4 ptr", {32'd0, cmd_ptr}, {32'd0, exp_ptr});
    chk(ok ? "R6 irq" : "R5 irq", {61'd0, irqv()}, {61'd0, exp_irq});
    chk("R10 idle", {63'd0, busy}, 64'd0);
    @(negedge clk);
    chk("R2 one-cycle strobes", {61'd0, cmd_ptr_we, load_req, ctl_evt_we}, 64'd0);
    chk("R9 sticky", {61'd0, irqv()}, {61'd0, exp_irq});
  endtask

  task automatic clear_irq(input logic [2:0] m);
    @(negedge clk); irq_clr = m;
    @(negedge clk); irq_clr = 0;
    exp_irq = exp_irq & ~m;
    chk("R9 clear", {61'd0, irqv()}, {61'd0, exp_irq});
  endtask

  task automatic t_reset();
    chk("R1 strobes", {59'd0, ctl_evt_we, dsc_stat_we, cmd_ptr_we, load_req, busy}, 64'd0);
    chk("R1 irq", {61'd0, irqv()}, 64'd0);
    chk("R1 ptr", {32'd0, cmd_ptr}, 64'd0);
  endtask

  // Back-to-back: accept in the result cycle.
  task automatic t_back_to_back();
    @(negedge clk);
    done_vld = 1; done_ok = 1; evt_code = 5'h11; z_fld = 0; int_fld = 0;
    @(negedge clk); done_vld = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R10 idle in result cycle", {63'd0, busy}, 64'd0);
    done_vld = 1; evt_code = 5'h12;
    @(negedge clk); done_vld = 0;
    chk("R10 accepted", {63'd0, ctl_evt_we}, 64'd1);
    chk("R10 evt", {59'd0, ctl_evt_val}, 64'h12);
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    #100000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; done_vld = 0; done_ok = 0; evt_code = 0; xfer_stat = 0; res_cnt = 0;
    int_fld = 0; z_fld = 0; branch_addr = 0; desc_addr = 0; ctx_resp = 0; irq_clr = 0;
    exp_ptr = 0; exp_irq = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    // R4 R5: failure without interrupt, unaligned address
    run_done(0, 5'h1E, 16'h1234, 16'h0040, 2'b01, 4'h0, 32'hAAAA_0000, 32'h1000_0ABC, 0, 0, 3'b0);
    // R5: failure with interrupt
    run_done(0, 5'h0B, 16'hFFFF, 16'hFFFF, 2'b11, 4'h3, 32'h0, 32'h2000_001F, 1, 0, 3'b0);
    clear_irq(3'b001);
    // R6 R7: success, request, stop
    run_done(1, 5'h11, 16'h8001, 16'h0000, 2'b11, 4'h0, 32'h5555_5555, 32'h3000_0000, 0, 0, 3'b0);
    // R6 R8: success, response, branch with Z=8
    run_done(1, 5'h12, 16'h0001, 16'h0010, 2'b11, 4'h8, 32'h4000_1237, 32'h3000_0010, 1, 0, 3'b0);
    // R6: no interrupt for 2'b10
    clear_irq(3'b110);
    run_done(1, 5'h11, 16'h0002, 16'h0020, 2'b10, 4'h1, 32'h5000_00F0, 32'h0, 0, 0, 3'b0);
    // R3: done_vld while busy ignored
    run_done(1, 5'h05, 16'h0003, 16'h0030, 2'b00, 4'h0, 32'h6000_0000, 32'h7000_0040, 0, 1, 3'b0);
    // R9: set wins over clear in same cycle
    run_done(1, 5'h11, 16'h0004, 16'h0000, 2'b11, 4'h0, 32'h0, 32'h0, 0, 0, 3'b010);
    exp_irq[1] = 1;
    chk("R9 set wins", {63'd0, irq_rqst}, 64'd1);
    clear_irq(3'b010);
    t_back_to_back();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule